// File: doc/BRIEF.md
# Per-Port Write Data-Unit Buffer Controller

This block connects one image-processing module's write port to a shared write-buffer memory. It takes a stream of bytes, and a marker on the final byte of each frame. It packs the bytes into fixed 256-byte data units, which it keeps in a small ring of slots. The number of slots is chosen at elaboration and is either 2 or 4.

To write each byte, the block raises a request toward a fixed-priority arbiter and presents its own priority level with it. A byte is taken only in a cycle in which the arbiter grants the request and the current slot is free. A slot is closed when its unit fills, or when the frame ends. For each closed slot the block places a transfer command on a valid/ready handshake. The command carries the slot index, the number of valid bytes and an end-of-frame flag.

A slot becomes free again only after two things have happened: its command has been accepted, and the downstream side has reported that the transfer is complete. While the slot being filled is not free, the input is held back.

Top module: `wdu_write_port`

## Requirements
- R1: After reset every slot is free, the fill position is slot 0 at offset 0 (`buf_addr_o` = 0), and `cmd_valid_o` is low.
- R2: A byte is accepted in a cycle with `in_valid_i`, `in_ready_o` and `buf_gnt_i` all high. In that cycle `buf_we_o` is high, `buf_data_o` equals `in_data_i`, and `buf_addr_o` equals slot × 256 + offset. `buf_we_o` is low in every other cycle.
- R3: The 256th accepted byte of a slot closes that slot. Its command carries a byte count of 256, and the next byte goes to offset 0 of the next slot.
- R4: An accepted byte that carries `in_eof_i` closes the slot it lands in. Its command carries `cmd_eof_o` = 1 and a byte count equal to the number of bytes in that slot (1 to 256). Commands for slots closed only because they are full carry `cmd_eof_o` = 0.
- R5: When a frame ends exactly on a unit boundary, the block issues one command, with a count of 256 and `cmd_eof_o` = 1. No zero-length command follows it.
- R6: Slots are filled in ring order, wrapping modulo the slot count. Commands are presented in the same order, so the k-th command since reset names slot k mod NUM_SLOTS. `cmd_valid_o` is high whenever a closed slot's command has not yet been accepted.
- R7: A closed slot is not written again until its command has been accepted and a `done_i` naming it has arrived. While the slot being filled is not free, `in_ready_o` stays low, so with no commands accepted at most NUM_SLOTS × 256 bytes enter the block.
- R8: While `cmd_valid_o` is high and `cmd_ready_i` is low, the command's slot, count and end-of-frame flag do not change.
- R9: A `done_i` pulse is ignored if it names a slot whose command has not yet been accepted, or a slot that is free.
- R10: `buf_req_o` is high exactly when `in_valid_i` is high and the slot being filled is free. `buf_prio_o` always shows the parameter PRIO_LVL, in which 0 is the highest priority and 14 the lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted this cycle when valid |
| in_data_i | input | DATA_W | Input byte |
| in_eof_i | input | 1 | The current byte is the last byte of its frame |
| buf_req_o | output | 1 | Request for the shared buffer memory |
| buf_prio_o | output | PRIO_W | Fixed arbitration priority of this port |
| buf_gnt_i | input | 1 | Grant from the arbiter |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | SLOT_W+8 | Buffer write address {slot, offset} |
| buf_data_o | output | DATA_W | Buffer write data |
| cmd_valid_o | output | 1 | Transfer command valid |
| cmd_ready_i | input | 1 | Transfer command accepted |
| cmd_slot_o | output | SLOT_W | Slot to transfer |
| cmd_bytes_o | output | 9 | Valid byte count, 1 to 256 |
| cmd_eof_o | output | 1 | Unit closed by end of frame |
| done_i | input | 1 | Downstream transfer complete |
| done_slot_i | input | SLOT_W | Slot whose transfer completed |

## Verification
The bench runs three kinds of frame. One is 600 bytes long and ends partway through a unit. One is exactly 512 bytes, so it ends on a unit boundary; a design that treated the boundary and the end of frame as separate events would emit a trailing zero-length command. The last is a single byte, which must give a count of 1 rather than 0 or 256.

With commands blocked, the bench fills every slot and checks that input stalls after exactly NUM_SLOTS × 256 bytes. A design that reused a slot early would overwrite data that had not yet been sent.

Stray completions are aimed at slots whose commands are still pending. A design that freed a slot on such a pulse would accept input into a slot that has not been sent. Grant and command-ready are randomised throughout, so a design that dropped or moved a command while it was stalled would be caught by the check on every clock.

// File: rtl/wdu_pkg.sv
package wdu_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_PEND = 2'd1,
    SLOT_XFER = 2'd2
  } slot_state_e;
endpackage

// File: rtl/wdu_fill_ctrl.sv
module wdu_fill_ctrl #(
  parameter int NUM_SLOTS = 4,
  parameter int DU_BYTES  = 256,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int OFF_W  = $clog2(DU_BYTES),
  localparam int CNT_W  = OFF_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              eof_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              close_o,
  output logic [CNT_W-1:0]  close_bytes_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [OFF_W-1:0]  off_q;
  logic              last_byte;

  assign last_byte     = (off_q == OFF_W'(DU_BYTES - 1));
  assign close_o       = accept_i & (last_byte | eof_i);
  assign close_bytes_o = {1'b0, off_q} + CNT_W'(1);
  assign slot_o        = slot_q;
  assign off_o         = off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      off_q  <= '0;
    end else if (accept_i) begin
      if (close_o) begin
        off_q  <= '0;
        slot_q <= (slot_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  // R3: a unit never spans more than DU_BYTES accepted bytes
  p_unit_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |=> (off_q == '0));
  // R6: the slot changes only on closure
  p_slot_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close_o |=> $stable(slot_q));
endmodule

// File: rtl/wdu_slot_tracker.sv
module wdu_slot_tracker
  import wdu_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 9,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            close_i,
  input  logic [SLOT_W-1:0]               close_slot_i,
  input  logic [CNT_W-1:0]                close_bytes_i,
  input  logic                            close_eof_i,
  input  logic                            issue_i,
  input  logic [SLOT_W-1:0]               issue_slot_i,
  input  logic                            done_i,
  input  logic [SLOT_W-1:0]               done_slot_i,
  output logic [NUM_SLOTS-1:0]            free_o,
  output logic [NUM_SLOTS-1:0]            pend_o,
  output logic [NUM_SLOTS-1:0][CNT_W-1:0] bytes_o,
  output logic [NUM_SLOTS-1:0]            eof_o
);
  slot_state_e state_q [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic close_me, issue_me, done_me;
    assign close_me = close_i & (close_slot_i == SLOT_W'(i));
    assign issue_me = issue_i & (issue_slot_i == SLOT_W'(i));
    assign done_me  = done_i  & (done_slot_i  == SLOT_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_q[i] <= SLOT_FREE;
        bytes_o[i] <= '0;
        eof_o[i]   <= 1'b0;
      end else begin
        unique case (state_q[i])
          SLOT_FREE: if (close_me) begin
            state_q[i] <= SLOT_PEND;
            bytes_o[i] <= close_bytes_i;
            eof_o[i]   <= close_eof_i;
          end
          SLOT_PEND: if (issue_me) state_q[i] <= SLOT_XFER;
          SLOT_XFER: if (done_me)  state_q[i] <= SLOT_FREE; // R9: done elsewhere ignored
          default:   state_q[i] <= SLOT_FREE;
        endcase
      end
    end

    assign free_o[i] = (state_q[i] == SLOT_FREE);
    assign pend_o[i] = (state_q[i] == SLOT_PEND);
  end

  // R7: the fill side only closes a slot that is free
  p_close_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |-> (state_q[close_slot_i] == SLOT_FREE));
  // R6: the command side only issues pending slots
  p_issue_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> (state_q[issue_slot_i] == SLOT_PEND));
endmodule

// File: rtl/wdu_cmd_issue.sv
module wdu_cmd_issue #(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 9,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_SLOTS-1:0]            pend_i,
  input  logic [NUM_SLOTS-1:0][CNT_W-1:0] bytes_i,
  input  logic [NUM_SLOTS-1:0]            eof_i,
  input  logic                            cmd_ready_i,
  output logic                            cmd_valid_o,
  output logic [SLOT_W-1:0]               cmd_slot_o,
  output logic [CNT_W-1:0]                cmd_bytes_o,
  output logic                            cmd_eof_o,
  output logic                            issue_o
);
  logic [SLOT_W-1:0] ptr_q;

  assign cmd_valid_o = pend_i[ptr_q];
  assign cmd_slot_o  = ptr_q;
  assign cmd_bytes_o = bytes_i[ptr_q];
  assign cmd_eof_o   = eof_i[ptr_q];
  assign issue_o     = cmd_valid_o & cmd_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (issue_o) ptr_q <= (ptr_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : ptr_q + 1'b1;
  end

  // R8: a stalled command holds its contents
  p_cmd_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_slot_o) && $stable(cmd_bytes_o) && $stable(cmd_eof_o)));
endmodule

// File: rtl/wdu_write_port.sv
module wdu_write_port #(
  parameter int NUM_SLOTS = 4,
  parameter int DU_BYTES  = 256,
  parameter int DATA_W    = 8,
  parameter int PRIO_W    = 4,
  parameter int PRIO_LVL  = 3,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int OFF_W  = $clog2(DU_BYTES),
  localparam int CNT_W  = OFF_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [DATA_W-1:0]       in_data_i,
  input  logic                    in_eof_i,
  output logic                    buf_req_o,
  output logic [PRIO_W-1:0]       buf_prio_o,
  input  logic                    buf_gnt_i,
  output logic                    buf_we_o,
  output logic [SLOT_W+OFF_W-1:0] buf_addr_o,
  output logic [DATA_W-1:0]       buf_data_o,
  output logic                    cmd_valid_o,
  input  logic                    cmd_ready_i,
  output logic [SLOT_W-1:0]       cmd_slot_o,
  output logic [CNT_W-1:0]        cmd_bytes_o,
  output logic                    cmd_eof_o,
  input  logic                    done_i,
  input  logic [SLOT_W-1:0]       done_slot_i
);
  initial assert (NUM_SLOTS == 2 || NUM_SLOTS == 4);

  logic [SLOT_W-1:0]               wr_slot;
  logic [OFF_W-1:0]                wr_off;
  logic                            close;
  logic [CNT_W-1:0]                close_bytes;
  logic [NUM_SLOTS-1:0]            free_vec, pend_vec, eof_vec;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] bytes_arr;
  logic                            issue;
  logic                            slot_free, accept;

  assign slot_free  = free_vec[wr_slot];
  assign buf_req_o  = in_valid_i & slot_free;
  assign in_ready_o = slot_free & buf_gnt_i;
  assign accept     = in_valid_i & in_ready_o;
  assign buf_prio_o = PRIO_W'(PRIO_LVL);
  assign buf_we_o   = accept;
  assign buf_addr_o = {wr_slot, wr_off};
  assign buf_data_o = in_data_i;

  wdu_fill_ctrl #(.NUM_SLOTS(NUM_SLOTS), .DU_BYTES(DU_BYTES)) u_fill (
    .clk_i, .rst_ni, .accept_i(accept), .eof_i(in_eof_i),
    .slot_o(wr_slot), .off_o(wr_off), .close_o(close), .close_bytes_o(close_bytes)
  );

  wdu_slot_tracker #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_track (
    .clk_i, .rst_ni,
    .close_i(close), .close_slot_i(wr_slot), .close_bytes_i(close_bytes),
    .close_eof_i(in_eof_i),
    .issue_i(issue), .issue_slot_i(cmd_slot_o),
    .done_i, .done_slot_i,
    .free_o(free_vec), .pend_o(pend_vec), .bytes_o(bytes_arr), .eof_o(eof_vec)
  );

  wdu_cmd_issue #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_cmd (
    .clk_i, .rst_ni, .pend_i(pend_vec), .bytes_i(bytes_arr), .eof_i(eof_vec),
    .cmd_ready_i, .cmd_valid_o, .cmd_slot_o, .cmd_bytes_o, .cmd_eof_o,
    .issue_o(issue)
  );

  // R10: no request without data
  p_req_needs_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_req_o |-> in_valid_i);
  // R4: command counts stay within one unit and are never zero
  p_cmd_bytes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_bytes_o != '0 && cmd_bytes_o <= CNT_W'(DU_BYTES)));
  // R2: a write only happens under grant
  p_we_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> (buf_gnt_i && buf_req_o));
endmodule

// File: tb/tb_wdu_write_port.sv
module tb_wdu_write_port;
  localparam int N = 4;
  localparam int DU = 256;
  localparam int PRIO = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic in_valid = 0, in_ready, in_eof = 0;
  logic [7:0] in_data = 0;
  logic buf_req, buf_gnt = 0, buf_we;
  logic [3:0] buf_prio;
  logic [9:0] buf_addr;
  logic [7:0] buf_data;
  logic cmd_valid, cmd_ready = 0, cmd_eof;
  logic [1:0] cmd_slot;
  logic [8:0] cmd_bytes;
  logic done = 0;
  logic [1:0] done_slot = 0;

  wdu_write_port #(.NUM_SLOTS(N), .DU_BYTES(DU), .PRIO_LVL(PRIO)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data), .in_eof_i(in_eof),
    .buf_req_o(buf_req), .buf_prio_o(buf_prio), .buf_gnt_i(buf_gnt),
    .buf_we_o(buf_we), .buf_addr_o(buf_addr), .buf_data_o(buf_data),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_slot_o(cmd_slot),
    .cmd_bytes_o(cmd_bytes), .cmd_eof_o(cmd_eof),
    .done_i(done), .done_slot_i(done_slot)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: slot states 0 free, 1 pending, 2 transferring
  typedef struct { int slot; int bytes; bit eof; } cmd_t;
  int   m_slot = 0, m_off = 0;
  int   m_st [N];
  cmd_t exp_q[$];
  cmd_t log_q[$];
  int   dq[$];
  int   acc_cnt = 0;
  bit   mon_en = 0, gnt_full = 1, cmd_en = 1, spur_en = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      bit fr, acc;
      fr  = (m_st[m_slot] == 0);
      acc = in_valid && fr && buf_gnt;
      chk(buf_req == (in_valid && fr), "R10 buf_req", buf_req, in_valid && fr);
      chk(buf_prio == PRIO, "R10 prio", buf_prio, PRIO);
      chk(in_ready == (fr && buf_gnt), "R7 in_ready", in_ready, fr && buf_gnt);
      chk(buf_we == acc, "R2 buf_we", buf_we, acc);
      if (acc) begin
        chk(buf_addr == m_slot * DU + m_off, "R2 addr", buf_addr, m_slot * DU + m_off);
        chk(buf_data == in_data, "R2 data", buf_data, in_data);
      end
      chk(cmd_valid == (exp_q.size() > 0), "R6 cmd_valid", cmd_valid, exp_q.size() > 0);
      if (cmd_valid && exp_q.size() > 0) begin
        chk(cmd_slot == exp_q[0].slot, "R6 cmd_slot", cmd_slot, exp_q[0].slot);
        chk(cmd_bytes == exp_q[0].bytes, "R3 cmd_bytes", cmd_bytes, exp_q[0].bytes);
        chk(cmd_eof == exp_q[0].eof, "R4 cmd_eof", cmd_eof, exp_q[0].eof);
      end
      // model update: completion, then issue, then fill (all on pre-edge state)
      if (done && m_st[done_slot] == 2) m_st[done_slot] = 0;
      if (cmd_valid && cmd_ready && exp_q.size() > 0) begin
        cmd_t c;
        c = exp_q.pop_front();
        m_st[c.slot] = 2;
        dq.push_back(c.slot);
        log_q.push_back('{int'(cmd_slot), int'(cmd_bytes), cmd_eof});
      end
      if (acc) begin
        acc_cnt++;
        if (m_off == DU - 1 || in_eof) begin
          exp_q.push_back('{m_slot, m_off + 1, in_eof});
          m_st[m_slot] = 1;
          m_slot = (m_slot + 1) % N;
          m_off = 0;
        end else m_off++;
      end
    end
  end

  // environment: grant, command ready, completions
  initial forever begin
    @(posedge clk); #1;
    buf_gnt   = gnt_full ? 1'b1 : ($urandom % 3 != 0);
    cmd_ready = cmd_en && ($urandom % 3 != 0);
    done = 0;
    if (dq.size() > 0 && ($urandom % 4 == 0)) begin
      done = 1; done_slot = 2'(dq.pop_front());
    end else if (spur_en && dq.size() == 0) begin
      done = 1; done_slot = 2'($urandom % N);
    end
  end

  task automatic send_frame(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_data = 8'(i * 7 + 3); in_eof = (i == n - 1);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
    end
    @(posedge clk); #1;
    in_valid = 0; in_eof = 0;
  endtask

  task automatic drain();
    forever begin
      @(negedge clk);
      if (exp_q.size() == 0 && dq.size() == 0 && m_st[0] == 0 && m_st[1] == 0 &&
          m_st[2] == 0 && m_st[3] == 0) break;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base, a0;
    for (int s = 0; s < N; s++) m_st[s] = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cmd_valid == 0, "R1 cmd_valid after reset", cmd_valid, 0);
    chk(buf_addr == 0, "R1 addr after reset", buf_addr, 0);
    chk(in_ready == 1, "R1 all slots free", in_ready, 1);
    mon_en = 1;
    gnt_full = 0;

    // frame ending mid-unit
    base = log_q.size();
    send_frame(600); drain();
    chk(log_q.size() - base == 3, "R3 command count 600B", log_q.size() - base, 3);
    chk(log_q[base].bytes == 256 && !log_q[base].eof, "R3 first unit full", log_q[base].bytes, 256);
    chk(log_q[base+1].bytes == 256 && !log_q[base+1].eof, "R3 second unit full", log_q[base+1].bytes, 256);
    chk(log_q[base+2].bytes == 88, "R4 partial count", log_q[base+2].bytes, 88);
    chk(log_q[base+2].eof == 1, "R4 partial eof", log_q[base+2].eof, 1);

    // frame ending on a boundary
    base = log_q.size();
    send_frame(512); drain();
    chk(log_q.size() - base == 2, "R5 no zero-length command", log_q.size() - base, 2);
    chk(log_q[base+1].bytes == 256, "R5 boundary count", log_q[base+1].bytes, 256);
    chk(log_q[base+1].eof == 1, "R5 boundary eof", log_q[base+1].eof, 1);

    // single-byte frame
    base = log_q.size();
    send_frame(1); drain();
    chk(log_q[base].bytes == 1 && log_q[base].eof, "R4 one byte frame", log_q[base].bytes, 1);

    // back-pressure with commands blocked
    cmd_en = 0; gnt_full = 1;
    a0 = acc_cnt;
    @(posedge clk); #1 in_valid = 1; in_eof = 0;
    repeat (N * DU + 20) @(posedge clk);
    @(negedge clk);
    chk(acc_cnt - a0 == N * DU, "R7 bytes before stall", acc_cnt - a0, N * DU);
    chk(in_ready == 0, "R7 stalled ready", in_ready, 0);
    @(posedge clk); #1 in_valid = 0;
    cmd_en = 1; gnt_full = 0;
    base = log_q.size();
    send_frame(10); drain();
    chk(log_q[log_q.size()-1].bytes == 10 && log_q[log_q.size()-1].eof,
        "R7 resumed tail", log_q[log_q.size()-1].bytes, 10);

    // stray completions against pending slots
    cmd_en = 0; gnt_full = 1;
    send_frame(N * DU);
    spur_en = 1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 0, "R9 pending slots not freed", in_ready, 0);
    chk(cmd_valid == 1, "R9 command still pending", cmd_valid, 1);
    spur_en = 0; cmd_en = 1; gnt_full = 0;
    drain();
    send_frame(300); drain();

    // ring order over the whole run
    for (int k = 0; k < log_q.size(); k++)
      chk(log_q[k].slot == k % N, "R6 ring order", log_q[k].slot, k % N);

    finish_run();
  end
endmodule